// File: doc/BRIEF.md
# Digit Write Sequencer with Bit-Line Recovery

This block is the control logic for one group of sense/digit channels in a static memory stack. The channels are split into halves. A half takes part in a cycle only when all of its active-low data-enable inputs are low together. While the active-low write enable is held low, every enabled bit drives exactly one line of its bit-line pair, and the data value picks which line. When the write enable is released, the digit drivers go idle and a recovery driver pulls the bit lines back to rest. Recovery ends after a fixed number of cycles or earlier on an external done pulse. It may overlap the cycle that follows.

Reads need the write enable high and at least one half enabled. Sensing is held off while the recovery driver is on. Once sensing starts, a valid flag rises only after a programmable settling delay, so the system strobes data near the end of the cycle rather than at its start. Every driver state is an abstract control signal. Levels and currents belong to the analog circuit around the block.

Top module: `digit_write_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, all drive controls, the recovery enable, the sense enables, the data outputs and the read-valid flag are low.
- R2: Half h (data bits h*HALF_BITS upward, enables h*EN_PER_HALF upward) is enabled only when every one of its data-enable inputs is 0 at once. A half with even one enable at 1 stays disabled.
- R3: After each clock edge that samples write enable at 0, every bit of an enabled half has driveTrue equal to its data bit and driveComp equal to its inverse. This takes one cycle and follows data changes on every cycle.
- R4: During a write, both drive controls of every bit in a disabled half are 0, and no bit ever has both controls at 1.
- R5: At the edge that samples write enable returning to 1 after a write, all drive controls turn off and the recovery enable turns on.
- R6: With no done pulse, the recovery enable stays on for exactly RECOV_CYCLES cycles (default 4) and then turns off.
- R7: When recovDone is 1 at an edge during recovery (USE_EXT_DONE=1), recovery ends at that edge.
- R8: A write enable falling during recovery is accepted. At the next edge recovery ends and drive starts in the same cycle.
- R9: Drive and recovery are never active in the same cycle. With write enable high and recovery over, all drivers are off.
- R10: One cycle after an edge where write enable is 1 and no recovery remains, senseEn[h] equals the enable state of half h.
- R11: readValid rises SENSE_DELAY cycles (default 3) after the sense-enable pattern turns on or changes, is 0 before that, and is 0 whenever no half senses.
- R12: dataOut carries the sensed inputs of halves whose sense enable is on, with one cycle of latency, and is 0 for every other half.
- R13: A read requested during recovery gets no sense enable until the edge at which recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | HALF_BITS*NUM_HALVES | Write data, one bit per bit-line pair |
| dataEnN | input | EN_PER_HALF*NUM_HALVES | Active-low data enables, grouped per half |
| writeEnN | input | 1 | Active-low write enable |
| recovDone | input | 1 | External recovery-complete pulse |
| senseIn | input | HALF_BITS*NUM_HALVES | Comparator results from the sense amplifiers |
| driveTrue | output | HALF_BITS*NUM_HALVES | Drive the true line of each pair |
| driveComp | output | HALF_BITS*NUM_HALVES | Drive the complement line of each pair |
| recovOn | output | 1 | Bit-line recovery driver enable |
| senseEn | output | NUM_HALVES | Per-half sense path enable |
| dataOut | output | HALF_BITS*NUM_HALVES | Gated sensed data |
| readValid | output | 1 | Sensed data has settled |

## Verification
Drive controls, the recovery enable, the sense enables and dataOut are all registered. Each one is due right after the first clock edge that samples the causing input. The bench changes inputs one time unit after a rising edge and checks outputs one time unit after the next edge. Recovery length is counted edge by edge from the release of write enable: RECOV_CYCLES checks see it on and the following one sees it off. readValid is checked as low on each of the first SENSE_DELAY-1 edges after the sense pattern settles and as high on the SENSE_DELAY-th edge.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_DRIVE   = 2'd1,
    PH_RECOVER = 2'd2
  } phase_e;

  // strobes from the sequencer to the datapath, valid for the coming edge
  typedef struct packed {
    logic driveLoad;  // digit drivers follow data at this edge
    logic senseOk;    // sense paths may open at this edge
  } strobes_t;

endpackage

// File: rtl/dws_ctrl.sv
module dws_ctrl
  import dws_pkg::*;
#(
  parameter int NUM_HALVES   = 2,
  parameter int RECOV_CYCLES = 4,
  parameter int SENSE_DELAY  = 3,
  parameter bit USE_EXT_DONE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  writeEnN,
  input  logic                  recovDone,
  input  logic [NUM_HALVES-1:0] halfEn,
  input  logic [NUM_HALVES-1:0] senseEnQ,
  output strobes_t              strobes,
  output logic                  recovOn,
  output logic                  readValid
);

  localparam int REC_W = (RECOV_CYCLES > 1) ? $clog2(RECOV_CYCLES) : 1;
  localparam int SEN_W = (SENSE_DELAY > 0) ? $clog2(SENSE_DELAY + 1) : 1;
  localparam logic [REC_W-1:0] REC_LOAD = REC_W'(RECOV_CYCLES - 1);
  localparam logic [SEN_W-1:0] SEN_TOP  = SEN_W'(SENSE_DELAY);

  phase_e              phase, phaseNext;
  logic                weQ;
  logic                weFall;
  logic                recFlag;
  logic                extDone;
  logic                doneHit;
  logic [REC_W-1:0]    recCnt;
  logic [SEN_W-1:0]    senCnt;
  logic [NUM_HALVES-1:0] senseNext;

  // external completion is an optional variant
  generate
    if (USE_EXT_DONE) begin : g_extDone
      assign extDone = recovDone;
    end else begin : g_cntOnly
      assign extDone = 1'b0;
    end
  endgenerate

  assign weFall  = weQ & ~writeEnN;
  assign doneHit = (recCnt == '0) | extDone;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:    if (!writeEnN) phaseNext = PH_DRIVE;
      PH_DRIVE:   if (writeEnN)  phaseNext = recFlag ? PH_RECOVER : PH_IDLE;
      PH_RECOVER: begin
        if (!writeEnN)    phaseNext = PH_DRIVE;
        else if (doneHit) phaseNext = PH_IDLE;
      end
      default:    phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      weQ     <= 1'b1;
      recFlag <= 1'b0;
      recCnt  <= '0;
    end else begin
      phase <= phaseNext;
      weQ   <= writeEnN;
      // recovery flip-flop: set by the leading edge, cleared on completion
      if (weFall)
        recFlag <= 1'b1;
      else if (phase == PH_RECOVER && writeEnN && doneHit)
        recFlag <= 1'b0;
      if (phase != PH_RECOVER && phaseNext == PH_RECOVER)
        recCnt <= REC_LOAD;
      else if (phase == PH_RECOVER && recCnt != '0)
        recCnt <= recCnt - 1'b1;
    end
  end

  assign strobes.driveLoad = (phaseNext == PH_DRIVE);
  assign strobes.senseOk   = (phaseNext == PH_IDLE);
  assign recovOn           = (phase == PH_RECOVER);

  // settling delay of the sense path
  assign senseNext = strobes.senseOk ? halfEn : '0;

  always_ff @(posedge clk) begin
    if (!rstN)
      senCnt <= '0;
    else if (senseNext == '0 || senseNext != senseEnQ)
      senCnt <= '0;
    else if (senCnt != SEN_TOP)
      senCnt <= senCnt + 1'b1;
  end

  assign readValid = (senCnt == SEN_TOP) && (senseEnQ != '0);

endmodule

// File: rtl/dws_datapath.sv
module dws_datapath
  import dws_pkg::*;
#(
  parameter int HALF_BITS   = 4,
  parameter int NUM_HALVES  = 2,
  parameter int EN_PER_HALF = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [HALF_BITS*NUM_HALVES-1:0]   dataIn,
  input  logic [EN_PER_HALF*NUM_HALVES-1:0] dataEnN,
  input  logic [HALF_BITS*NUM_HALVES-1:0]   senseIn,
  input  strobes_t                         strobes,
  output logic [NUM_HALVES-1:0]            halfEn,
  output logic [HALF_BITS*NUM_HALVES-1:0]   driveTrue,
  output logic [HALF_BITS*NUM_HALVES-1:0]   driveComp,
  output logic [NUM_HALVES-1:0]            senseEn,
  output logic [HALF_BITS*NUM_HALVES-1:0]   dataOut
);

  generate
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      logic [HALF_BITS-1:0] dSlice;
      logic                 driveHere;
      logic                 senseHere;

      // coincidence of all low enables opens the half
      assign halfEn[h]  = &(~dataEnN[h*EN_PER_HALF +: EN_PER_HALF]);
      assign dSlice     = dataIn[h*HALF_BITS +: HALF_BITS];
      assign driveHere  = strobes.driveLoad & halfEn[h];
      assign senseHere  = strobes.senseOk & halfEn[h];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          driveTrue[h*HALF_BITS +: HALF_BITS] <= '0;
          driveComp[h*HALF_BITS +: HALF_BITS] <= '0;
          senseEn[h]                          <= 1'b0;
          dataOut[h*HALF_BITS +: HALF_BITS]   <= '0;
        end else begin
          driveTrue[h*HALF_BITS +: HALF_BITS] <= driveHere ? dSlice  : '0;
          driveComp[h*HALF_BITS +: HALF_BITS] <= driveHere ? ~dSlice : '0;
          senseEn[h]                          <= senseHere;
          dataOut[h*HALF_BITS +: HALF_BITS]   <=
            senseHere ? senseIn[h*HALF_BITS +: HALF_BITS] : '0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/digit_write_seq.sv
module digit_write_seq
  import dws_pkg::*;
#(
  parameter int HALF_BITS    = 4,
  parameter int NUM_HALVES   = 2,
  parameter int EN_PER_HALF  = 2,
  parameter int RECOV_CYCLES = 4,
  parameter int SENSE_DELAY  = 3,
  parameter bit USE_EXT_DONE = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [HALF_BITS*NUM_HALVES-1:0]   dataIn,
  input  logic [EN_PER_HALF*NUM_HALVES-1:0] dataEnN,
  input  logic                             writeEnN,
  input  logic                             recovDone,
  input  logic [HALF_BITS*NUM_HALVES-1:0]   senseIn,
  output logic [HALF_BITS*NUM_HALVES-1:0]   driveTrue,
  output logic [HALF_BITS*NUM_HALVES-1:0]   driveComp,
  output logic                             recovOn,
  output logic [NUM_HALVES-1:0]            senseEn,
  output logic [HALF_BITS*NUM_HALVES-1:0]   dataOut,
  output logic                             readValid
);

  strobes_t              strobes;
  logic [NUM_HALVES-1:0] halfEn;

  dws_ctrl #(
    .NUM_HALVES   (NUM_HALVES),
    .RECOV_CYCLES (RECOV_CYCLES),
    .SENSE_DELAY  (SENSE_DELAY),
    .USE_EXT_DONE (USE_EXT_DONE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .writeEnN  (writeEnN),
    .recovDone (recovDone),
    .halfEn    (halfEn),
    .senseEnQ  (senseEn),
    .strobes   (strobes),
    .recovOn   (recovOn),
    .readValid (readValid)
  );

  dws_datapath #(
    .HALF_BITS   (HALF_BITS),
    .NUM_HALVES  (NUM_HALVES),
    .EN_PER_HALF (EN_PER_HALF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .dataEnN   (dataEnN),
    .senseIn   (senseIn),
    .strobes   (strobes),
    .halfEn    (halfEn),
    .driveTrue (driveTrue),
    .driveComp (driveComp),
    .senseEn   (senseEn),
    .dataOut   (dataOut)
  );

endmodule

// File: rtl/digit_write_seq_chk.sv
module digit_write_seq_chk #(
  parameter int HALF_BITS    = 4,
  parameter int NUM_HALVES   = 2,
  parameter int EN_PER_HALF  = 2,
  parameter int RECOV_CYCLES = 4,
  parameter bit USE_EXT_DONE = 1'b1
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [HALF_BITS*NUM_HALVES-1:0]   dataIn,
  input logic [EN_PER_HALF*NUM_HALVES-1:0] dataEnN,
  input logic                             writeEnN,
  input logic                             recovDone,
  input logic [HALF_BITS*NUM_HALVES-1:0]   driveTrue,
  input logic [HALF_BITS*NUM_HALVES-1:0]   driveComp,
  input logic                             recovOn,
  input logic [NUM_HALVES-1:0]            senseEn,
  input logic [HALF_BITS*NUM_HALVES-1:0]   dataOut,
  input logic                             readValid
);

  localparam int DW = HALF_BITS * NUM_HALVES;

  logic [DW-1:0] wrMask;
  logic [DW-1:0] rdMask;
  logic [31:0]   recRun;

  always_comb begin
    for (int h = 0; h < NUM_HALVES; h++) begin
      for (int b = 0; b < HALF_BITS; b++) begin
        wrMask[h*HALF_BITS + b] = (dataEnN[h*EN_PER_HALF +: EN_PER_HALF] == '0);
        rdMask[h*HALF_BITS + b] = senseEn[h];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) recRun <= '0;
    else       recRun <= recovOn ? recRun + 1 : '0;
  end

  assert_write_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    !writeEnN |=> (driveTrue == $past(dataIn & wrMask)));

  assert_pair_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !writeEnN |=> ((driveTrue ^ driveComp) == $past(wrMask)));

  assert_pair_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((driveTrue & driveComp) == '0));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeEnN) |=> (recovOn && driveTrue == '0 && driveComp == '0));

  assert_recov_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    recovOn |-> (recRun < RECOV_CYCLES));

  generate
    if (USE_EXT_DONE) begin : g_doneChk
      assert_ext_done_R7: assert property (@(posedge clk) disable iff (!rstN)
        (recovOn && recovDone) |=> !recovOn);
    end
  endgenerate

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    recovOn |-> ((driveTrue | driveComp) == '0));

  assert_sense_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    (senseEn != '0) |-> (!recovOn && (driveTrue | driveComp) == '0));

  assert_valid_sense_R11: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> (senseEn != '0));

  assert_out_gated_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((dataOut & ~rdMask) == '0));

endmodule

bind digit_write_seq digit_write_seq_chk #(
  .HALF_BITS    (HALF_BITS),
  .NUM_HALVES   (NUM_HALVES),
  .EN_PER_HALF  (EN_PER_HALF),
  .RECOV_CYCLES (RECOV_CYCLES),
  .USE_EXT_DONE (USE_EXT_DONE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dataIn    (dataIn),
  .dataEnN   (dataEnN),
  .writeEnN  (writeEnN),
  .recovDone (recovDone),
  .driveTrue (driveTrue),
  .driveComp (driveComp),
  .recovOn   (recovOn),
  .senseEn   (senseEn),
  .dataOut   (dataOut),
  .readValid (readValid)
);

// File: tb/digit_write_seq_bench.sv
module digit_write_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HB  = 4;
  localparam int NH  = 2;
  localparam int EPH = 2;
  localparam int RC  = 4;
  localparam int SD  = 3;
  localparam int DW  = HB * NH;
  localparam int EW  = EPH * NH;

  logic          clk = 1'b0;
  logic          rstN;
  logic [DW-1:0] dataIn;
  logic [EW-1:0] dataEnN;
  logic          writeEnN;
  logic          recovDone;
  logic [DW-1:0] senseIn;
  logic [DW-1:0] driveTrue;
  logic [DW-1:0] driveComp;
  logic          recovOn;
  logic [NH-1:0] senseEn;
  logic [DW-1:0] dataOut;
  logic          readValid;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  digit_write_seq #(
    .HALF_BITS(HB), .NUM_HALVES(NH), .EN_PER_HALF(EPH),
    .RECOV_CYCLES(RC), .SENSE_DELAY(SD), .USE_EXT_DONE(1'b1)
  ) u_digit_write_seq (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataEnN(dataEnN),
    .writeEnN(writeEnN), .recovDone(recovDone), .senseIn(senseIn),
    .driveTrue(driveTrue), .driveComp(driveComp), .recovOn(recovOn),
    .senseEn(senseEn), .dataOut(dataOut), .readValid(readValid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // enabled-bit mask from the per-half enable rule (all enables of a half low)
  function automatic logic [DW-1:0] enMask(input logic [EW-1:0] en);
    logic [DW-1:0] m = '0;
    for (int h = 0; h < NH; h++)
      if (en[h*EPH +: EPH] == '0) m[h*HB +: HB] = '1;
    return m;
  endfunction

  function automatic logic [NH-1:0] halfBits(input logic [EW-1:0] en);
    logic [NH-1:0] s = '0;
    for (int h = 0; h < NH; h++) s[h] = (en[h*EPH +: EPH] == '0);
    return s;
  endfunction

  task automatic t_reset();
    rstN = 1'b0; writeEnN = 1'b1; dataEnN = '1; dataIn = '0;
    recovDone = 1'b0; senseIn = '0;
    repeat (3) tick();
    chk("R1", "drive in reset", {driveTrue, driveComp}, 32'h0);
    chk("R1", "misc in reset", {recovOn, senseEn, readValid, dataOut}, 32'h0);
    rstN = 1'b1;
    tick();
    chk("R1", "idle after reset", {driveTrue, driveComp, recovOn, senseEn, readValid}, 32'h0);
  endtask

  task automatic t_write(input logic [DW-1:0] d, input logic [EW-1:0] en, input string req);
    logic [DW-1:0] m = enMask(en);
    writeEnN = 1'b0; dataEnN = en; dataIn = d;
    tick();
    chk(req, "driveTrue", driveTrue, d & m);
    chk(req, "driveComp", driveComp, ~d & m);
    chk("R9", "no recovery while driving", recovOn, 1'b0);
    chk("R13", "no sense while driving", senseEn, '0);
  endtask

  task automatic t_release_timeout();
    writeEnN = 1'b1; dataEnN = '1;
    tick();
    chk("R5", "drivers off on release", {driveTrue, driveComp}, 32'h0);
    chk("R5", "recovery on at release", recovOn, 1'b1);
    for (int i = 1; i < RC; i++) begin
      tick();
      chk("R6", "recovery held", recovOn, 1'b1);
    end
    tick();
    chk("R6", "recovery ends after count", recovOn, 1'b0);
    chk("R9", "all off when idle", {driveTrue, driveComp}, 32'h0);
  endtask

  task automatic t_ext_done();
    t_write(8'h0F, 4'b0000, "R3");
    writeEnN = 1'b1; dataEnN = '1;
    tick();
    chk("R5", "recovery on", recovOn, 1'b1);
    recovDone = 1'b1;
    tick();
    chk("R7", "done pulse ends recovery", recovOn, 1'b0);
    recovDone = 1'b0;
  endtask

  task automatic t_overlap_write();
    t_write(8'hC3, 4'b0000, "R3");
    writeEnN = 1'b1;
    tick();
    chk("R5", "recovery on", recovOn, 1'b1);
    tick();
    chk("R6", "recovery still on", recovOn, 1'b1);
    t_write(8'h96, 4'b0000, "R8");
    chk("R8", "recovery cut by new write", recovOn, 1'b0);
    t_release_timeout();
  endtask

  task automatic t_read_after_write();
    t_write(8'hFF, 4'b0000, "R3");
    writeEnN = 1'b1; dataEnN = 4'b1100; senseIn = 8'h5A;
    tick();
    chk("R13", "no sense during recovery", senseEn, '0);
    chk("R12", "no data during recovery", dataOut, '0);
    for (int i = 1; i < RC; i++) begin
      tick();
      chk("R13", "sense held off", senseEn, '0);
    end
    tick();
    chk("R6", "recovery over", recovOn, 1'b0);
    chk("R10", "half0 sense opens", senseEn, halfBits(4'b1100));
    chk("R12", "half0 data only", dataOut, 8'h5A & enMask(4'b1100));
    chk("R11", "not valid at sense start", readValid, 1'b0);
    for (int i = 1; i < SD; i++) begin
      tick();
      chk("R11", "not valid yet", readValid, 1'b0);
    end
    tick();
    chk("R11", "valid after delay", readValid, 1'b1);
    dataEnN = 4'b0000; senseIn = 8'hA7;
    tick();
    chk("R10", "both halves sense", senseEn, 2'b11);
    chk("R11", "valid drops on new pattern", readValid, 1'b0);
    chk("R12", "full data", dataOut, 8'hA7);
    dataEnN = 4'b0110;
    tick();
    chk("R2", "one-low halves stay closed", senseEn, 2'b00);
    chk("R11", "no valid without sense", readValid, 1'b0);
    chk("R12", "data gated off", dataOut, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_write(8'hA5, 4'b0000, "R3");
    t_write(8'h3C, 4'b0000, "R3");
    t_write(8'h69, 4'b1100, "R4");
    t_write(8'hE1, 4'b0011, "R4");
    t_write(8'hFF, 4'b0110, "R2");
    t_write(8'h12, 4'b1101, "R2");
    t_release_timeout();
    t_ext_done();
    t_overlap_write();
    t_read_after_write();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule